// File: doc/BRIEF.md
# Multi-Mode Digital Phase Detector

This block compares a stream of reference edge pulses with a stream of feedback edge pulses. Both streams are already sampled into one fast clock domain. At each reference edge it forms a signed phase error word for a digital PLL loop filter. The lag is measured as the number of fast-clock samples from the most recent feedback edge to the reference edge. The caller supplies the nominal period in fast-clock ticks.

Four capture behaviours are selectable at run time:

- A phase/frequency mode covers one full cycle and drives the error to a limit when the edge pairing breaks.
- A nearest-edge mode folds the lag into plus or minus half a cycle.
- A binary early/late mode reports only the sign of the error.
- A multicycle mode counts whole-cycle slips in a signed counter that saturates at 8191 in either direction.

In multicycle mode the error word places the slip count above the fractional lag. The whole word then reads as one signed number. Changing the mode restarts the pairing state and the slip count.

Top module: `pd_multimode`

## Requirements
- R1: After reset, `err` is 0 and `err_valid` is 0.
- R2: A reference edge sampled on a clock edge raises `err_valid` for exactly the following cycle, and `err` is updated in that same cycle. `err_valid` is low in every other cycle, and `err` holds its value between updates.
- R3: Mode 0 (phase/frequency) reports the clamped lag. The lag is the number of clock samples from the last feedback edge to the reference edge: 0 when both arrive in the same cycle, and limited to `period`-1. If no feedback edge arrived since the previous reference edge, the error is +(2^(W-1)-1), where W is the width of `err`. If two or more feedback edges arrived, the error is -(2^(W-1)-1).
- R4: Mode 1 (nearest-edge) reports the clamped lag d when d <= floor(`period`/2). Otherwise it reports d-`period`.
- R5: Mode 2 (early/late) reports 0 when d = 0, +1 when 0 < d <= floor(`period`/2), and -1 otherwise.
- R6: Mode 3 (multicycle) reports cnt*2^TICK_W + d. The count cnt is a signed value in `err[TICK_W+CYC_W-1:TICK_W]`. It rises by one at each reference edge that has no feedback edge since the previous reference edge. It falls by one at each feedback edge that follows another feedback edge with no reference edge between them.
- R7: The multicycle count saturates at +8191 and -8191.
- R8: In the cycle where `mode` differs from the mode last applied, both edge inputs are ignored and no valid pulse follows. The slip count and the feedback pairing count are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | 1 | One-cycle pulse per reference edge |
| fb_edge | input | 1 | One-cycle pulse per feedback edge |
| period | input | TICK_W | Nominal cycle length in clock ticks (at least 2) |
| mode | input | 2 | 0 phase/frequency, 1 nearest-edge, 2 early/late, 3 multicycle |
| err | output | CYC_W+TICK_W | Signed phase error word |
| err_valid | output | 1 | High for one cycle with each new error |

## Verification
Every result is due one register stage after the clock edge that samples the reference pulse. The valid strobe and the new error both appear in the cycle after that edge. A mode change takes effect at the edge that sees it, so it suppresses the strobe in that same following cycle. The bench drives inputs on the falling edge and samples shortly after the next rising edge. It compares the outputs in every cycle against a running arithmetic model of lag, pairing count and slip count. This covers the cycles without a strobe, where `err` must hold its value.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int PD_TICK_W = 8;
    localparam int PD_CYC_W  = 14;

    typedef enum logic [1:0] {
        PD_PFD       = 2'd0,
        PD_NEAREST   = 2'd1,
        PD_EARLYLATE = 2'd2,
        PD_MULTI     = 2'd3
    } pd_mode_e;

    // Pairing view of the current cycle, handed from the edge tracker on.
    typedef struct packed {
        logic fire;      // accepted reference edge
        logic none;      // no feedback edge in this reference interval
        logic multi;     // two or more feedback edges in this interval
        logic fb_extra;  // feedback edge that follows another feedback edge
    } pd_pair_t;

    function automatic logic [1:0] pd_sat_inc2(input logic [1:0] v);
        return (v == 2'd3) ? v : v + 2'd1;
    endfunction

endpackage

// File: rtl/pd_edge_track.sv
module pd_edge_track
    import pd_pkg::*;
#(
    parameter int TICK_W = PD_TICK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_edge,
    input  logic              fb_edge,
    input  logic              mode_chg,
    output logic [TICK_W-1:0] lag_eff,
    output pd_pair_t          pair
);

    localparam logic [TICK_W-1:0] LAG_TOP = '1;

    logic [TICK_W-1:0] lag_q;
    logic [1:0]        fbc_q;
    logic [1:0]        fbc_eff;
    logic              fb_ok;
    logic              ref_ok;
    logic [TICK_W-1:0] lag_inc;

    assign fb_ok   = fb_edge && !mode_chg;
    assign ref_ok  = ref_edge && !mode_chg;
    assign lag_inc = (lag_q == LAG_TOP) ? lag_q : lag_q + 1'b1;
    assign lag_eff = fb_ok ? '0 : lag_q;
    assign fbc_eff = fb_ok ? pd_sat_inc2(fbc_q) : fbc_q;

    always_comb begin
        pair.fire     = ref_ok;
        pair.none     = (fbc_eff == 2'd0);
        pair.multi    = (fbc_eff >= 2'd2);
        pair.fb_extra = fb_ok && (fbc_q != 2'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lag_q <= LAG_TOP;
            fbc_q <= 2'd0;
        end else if (mode_chg) begin
            lag_q <= lag_inc;
            fbc_q <= 2'd0;
        end else begin
            lag_q <= fb_edge ? TICK_W'(1) : lag_inc;
            fbc_q <= ref_edge ? 2'd0 : fbc_eff;
        end
    end

endmodule

// File: rtl/pd_slip_count.sv
module pd_slip_count #(
    parameter int CYC_W = pd_pkg::PD_CYC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    inc,
    input  logic                    dec,
    output logic signed [CYC_W-1:0] cnt_next,
    output logic signed [CYC_W-1:0] cnt_q
);

    localparam logic signed [CYC_W-1:0] LIM = CYC_W'((1 << (CYC_W - 1)) - 1);
    localparam logic signed [CYC_W-1:0] ONE = CYC_W'(1);

    always_comb begin
        if (clear)                    cnt_next = '0;
        else if (inc && cnt_q != LIM)  cnt_next = cnt_q + ONE;
        else if (dec && cnt_q != -LIM) cnt_next = cnt_q - ONE;
        else                           cnt_next = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_next;
    end

endmodule

// File: rtl/pd_error_form.sv
module pd_error_form
    import pd_pkg::*;
#(
    parameter int TICK_W = PD_TICK_W,
    parameter int CYC_W  = PD_CYC_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  pd_mode_e                       mode,
    input  logic [TICK_W-1:0]              lag_eff,
    input  logic [TICK_W-1:0]              period,
    input  pd_pair_t                       pair,
    input  logic signed [CYC_W-1:0]        cnt_next,
    output logic signed [CYC_W+TICK_W-1:0] err,
    output logic                           err_valid
);

    localparam int ERR_W = CYC_W + TICK_W;
    localparam logic signed [ERR_W-1:0] MAXV = {1'b0, {(ERR_W-1){1'b1}}};
    localparam logic signed [ERR_W-1:0] P1   = ERR_W'(1);
    localparam logic signed [ERR_W-1:0] M1   = '1;

    logic [TICK_W-1:0]       dc;
    logic [TICK_W-1:0]       half;
    logic signed [ERR_W-1:0] dc_s;
    logic signed [ERR_W-1:0] per_s;
    logic signed [ERR_W-1:0] nxt;

    assign dc    = (lag_eff >= period) ? period - 1'b1 : lag_eff;
    assign half  = period >> 1;
    assign dc_s  = signed'(ERR_W'(dc));
    assign per_s = signed'(ERR_W'(period));

    always_comb begin
        unique case (mode)
            PD_PFD: begin
                if (pair.none)       nxt = MAXV;
                else if (pair.multi) nxt = -MAXV;
                else                 nxt = dc_s;
            end
            PD_NEAREST:   nxt = (dc <= half) ? dc_s : dc_s - per_s;
            PD_EARLYLATE: nxt = (dc == '0) ? '0 : ((dc <= half) ? P1 : M1);
            default:      nxt = signed'({cnt_next, dc});
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err       <= '0;
            err_valid <= 1'b0;
        end else begin
            err_valid <= pair.fire;
            if (pair.fire) err <= nxt;
        end
    end

endmodule

// File: rtl/pd_multimode.sv
module pd_multimode
    import pd_pkg::*;
#(
    parameter int TICK_W = PD_TICK_W,
    parameter int CYC_W  = PD_CYC_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ref_edge,
    input  logic                           fb_edge,
    input  logic [TICK_W-1:0]              period,
    input  logic [1:0]                     mode,
    output logic signed [CYC_W+TICK_W-1:0] err,
    output logic                           err_valid
);

    pd_mode_e                mode_q;
    logic                    mode_chg;
    logic [TICK_W-1:0]       lag_eff;
    pd_pair_t                pair;
    logic                    slip_on;
    logic signed [CYC_W-1:0] cnt_next;
    logic signed [CYC_W-1:0] cnt_q;

    assign mode_chg = (pd_mode_e'(mode) != mode_q);
    assign slip_on  = (mode_q == PD_MULTI);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PD_PFD;
        else     mode_q <= pd_mode_e'(mode);
    end

    pd_edge_track #(.TICK_W(TICK_W)) trk_i (
        .clk      (clk),
        .rst      (rst),
        .ref_edge (ref_edge),
        .fb_edge  (fb_edge),
        .mode_chg (mode_chg),
        .lag_eff  (lag_eff),
        .pair     (pair)
    );

    pd_slip_count #(.CYC_W(CYC_W)) slip_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (mode_chg),
        .inc      (slip_on && pair.fire && pair.none),
        .dec      (slip_on && pair.fb_extra),
        .cnt_next (cnt_next),
        .cnt_q    (cnt_q)
    );

    pd_error_form #(.TICK_W(TICK_W), .CYC_W(CYC_W)) form_i (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .lag_eff   (lag_eff),
        .period    (period),
        .pair      (pair),
        .cnt_next  (cnt_next),
        .err       (err),
        .err_valid (err_valid)
    );

endmodule

// File: rtl/pd_multimode_chk.sv
module pd_multimode_chk #(
    parameter int TICK_W = pd_pkg::PD_TICK_W,
    parameter int CYC_W  = pd_pkg::PD_CYC_W
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           ref_edge,
    input logic [TICK_W-1:0]              period,
    input logic [1:0]                     mode,
    input logic                           mode_chg,
    input logic signed [CYC_W-1:0]        cyc_cnt,
    input logic signed [CYC_W+TICK_W-1:0] err,
    input logic                           err_valid
);

    localparam int ERR_W = CYC_W + TICK_W;
    localparam logic signed [ERR_W-1:0] MAXV = {1'b0, {(ERR_W-1){1'b1}}};
    localparam logic signed [ERR_W-1:0] P1   = ERR_W'(1);
    localparam logic signed [ERR_W-1:0] M1   = '1;
    localparam logic signed [CYC_W-1:0] LIM  = CYC_W'((1 << (CYC_W - 1)) - 1);

    logic [TICK_W-1:0]       per_q;
    logic [1:0]              mode_p;
    logic signed [ERR_W-1:0] per_s;

    always_ff @(posedge clk) begin
        per_q  <= period;
        mode_p <= mode;
    end

    assign per_s = signed'(ERR_W'(per_q));

    AST_VALID_AFTER_REF: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $past(ref_edge)); // R2

    AST_PFD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (err_valid && mode_p == 2'd0) |->
            (err == MAXV || err == -MAXV || (err >= 0 && err < per_s))); // R3

    AST_NEAR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (err_valid && mode_p == 2'd1) |->
            (err > -per_s && err <= (per_s >>> 1))); // R4

    AST_EL_SIGN_ONLY: assert property (@(posedge clk) disable iff (rst)
        (err_valid && mode_p == 2'd2) |-> (err == 0 || err == P1 || err == M1)); // R5

    AST_SLIP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cyc_cnt <= LIM && cyc_cnt >= -LIM)); // R7

    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (cyc_cnt == 0 && !err_valid)); // R8

endmodule

bind pd_multimode pd_multimode_chk #(.TICK_W(TICK_W), .CYC_W(CYC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ref_edge  (ref_edge),
    .period    (period),
    .mode      (mode),
    .mode_chg  (mode_chg),
    .cyc_cnt   (cnt_q),
    .err       (err),
    .err_valid (err_valid)
);

// File: tb/pd_multimode_tb_top.sv
module pd_multimode_tb_top;

    localparam int TW    = 8;
    localparam int CW    = 14;
    localparam int EW    = TW + CW;
    localparam int MAXV  = (1 << (EW - 1)) - 1;
    localparam int LIM   = (1 << (CW - 1)) - 1;
    localparam int LAGMX = (1 << TW) - 1;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 ref_edge;
    logic                 fb_edge;
    logic [TW-1:0]        period;
    logic [1:0]           mode;
    logic signed [EW-1:0] err;
    logic                 err_valid;

    int checks = 0;
    int errors = 0;
    int m_lag, m_fbc, m_cnt, m_mode, m_hold;

    always #10 clk = ~clk;

    pd_multimode #(.TICK_W(TW), .CYC_W(CW)) dut_i (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .fb_edge(fb_edge),
        .period(period), .mode(mode), .err(err), .err_valid(err_valid)
    );

    function automatic string mtag(input int md);
        case (md)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick(input logic f, input logic r);
        int exp_v, exp_e, lag_e, fbc_e, dc, half;
        @(negedge clk);
        fb_edge  = f;
        ref_edge = r;
        exp_v = 0;
        exp_e = m_hold;
        if (int'(mode) != m_mode) begin
            m_mode = int'(mode);
            m_fbc  = 0;
            m_cnt  = 0;
            m_lag  = (m_lag < LAGMX) ? m_lag + 1 : LAGMX;
        end else begin
            lag_e = f ? 0 : m_lag;
            fbc_e = f ? ((m_fbc < 3) ? m_fbc + 1 : 3) : m_fbc;
            if (m_mode == 3) begin
                if (f && m_fbc != 0 && m_cnt > -LIM) m_cnt--;
                if (r && fbc_e == 0 && m_cnt < LIM) m_cnt++;
            end
            if (r) begin
                dc   = (lag_e >= int'(period)) ? int'(period) - 1 : lag_e;
                half = int'(period) / 2;
                case (m_mode)
                    0: exp_e = (fbc_e == 0) ? MAXV : ((fbc_e >= 2) ? -MAXV : dc);
                    1: exp_e = (dc <= half) ? dc : dc - int'(period);
                    2: exp_e = (dc == 0) ? 0 : ((dc <= half) ? 1 : -1);
                    default: exp_e = m_cnt * (1 << TW) + dc;
                endcase
                exp_v  = 1;
                m_hold = exp_e;
            end
            m_lag = f ? 1 : ((m_lag < LAGMX) ? m_lag + 1 : LAGMX);
            m_fbc = r ? 0 : fbc_e;
        end
        @(posedge clk);
        #1;
        check(exp_v ? "R2" : "R2/R8", int'(err_valid), exp_v);
        check(exp_v ? mtag(m_mode) : "R2", int'(err), exp_e);
    endtask

    task automatic pair_lag(input int j);
        if (j == 0) tick(1'b1, 1'b1);
        else begin
            tick(1'b1, 1'b0);
            for (int k = 1; k < j; k++) tick(1'b0, 1'b0);
            tick(1'b0, 1'b1);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ref_edge = 1'b0; fb_edge = 1'b0; period = 8'd8; mode = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", int'(err_valid), 0);
        check("R1", int'(err), 0);
        m_lag = LAGMX; m_fbc = 0; m_cnt = 0; m_mode = 0; m_hold = 0;

        // Lag sweeps across the three single-cycle modes, even and odd periods
        for (int p = 7; p <= 8; p++) begin
            period = 8'(p);
            for (int md = 0; md < 3; md++) begin
                mode = 2'(md);
                tick(1'b0, 1'b0);
                for (int j = 0; j <= p + 1; j++) pair_lag(j);
            end
        end

        // Phase/frequency limits: reference twice, then feedback twice
        mode = 2'd0; period = 8'd8;
        tick(1'b0, 1'b0);
        pair_lag(3);
        tick(1'b0, 1'b1);
        check("R3", int'(err), MAXV);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b1);
        check("R3", int'(err), -MAXV);

        // Multicycle slips both ways
        mode = 2'd3;
        tick(1'b0, 1'b0);
        pair_lag(2);
        for (int k = 0; k < 5; k++) tick(1'b0, 1'b1);
        check("R6", int'(err) >>> TW, 5);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b1);
        check("R6", int'(err) >>> TW, 3);

        // Mode change clears slip count and ignores edges in that cycle
        mode = 2'd1;
        tick(1'b1, 1'b1);
        mode = 2'd3;
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        check("R8", int'(err) >>> TW, 1);

        // Positive saturation
        for (int k = 0; k < LIM + 10; k++) tick(1'b0, 1'b1);
        check("R7", int'(err) >>> TW, LIM);
        // Negative saturation
        for (int k = 0; k < 2 * LIM + 20; k++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b1);
        check("R7", int'(err) >>> TW, -LIM);

        tick(1'b0, 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule